// File: doc/BRIEF.md
# Transmit Amplitude Fine Scaler

This block trims the amplitude of a stream of signed transmit samples by a small gain factor before they leave the modulator. The trim is a sign-magnitude coefficient: a direction bit picks gain above or below unity, and the remaining bits give the size of the correction in steps of one sixteenth. Two coefficient fields are held outside the block, one for each data rate (1 Mb/s and 2 Mb/s). The rate select input chooses which one applies.

A trim enable switches the correction on. With the trim off, samples pass through unchanged. A direct mode replaces the sample with a constant value from a configuration field, and that value is not scaled. The result is registered, so the output follows the input by one clock cycle, and the valid flag is delayed to match.

Top module: `tx_fine_scaler`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0 and out_sample is 0.
- R2: out_valid equals in_valid of the previous clock cycle.
- R3: With trim_en=1, direct_en=0 and coefficient bit 2 set, the output is s + floor(s*m/16), where s is in_sample read as two's complement and m is coefficient bits [1:0] as an unsigned number.
- R4: With trim_en=1, direct_en=0 and coefficient bit 2 clear, the output is s - floor(s*m/16). An output in this mode is never larger in magnitude than the input.
- R5: The trimmed result saturates to the signed 8-bit range, from -128 to 127.
- R6: rate_2m=0 selects coef_1m and rate_2m=1 selects coef_2m. The unselected field has no effect on the output.
- R7: With trim_en=0 and direct_en=0, out_sample equals in_sample. The coefficients have no effect.
- R8: With direct_en=1, out_sample equals direct_value, whatever the values of in_sample, trim_en, the rate and the coefficients.
- R9: In a cycle with in_valid=0, out_sample keeps its previous value on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 8 | Signed input sample from the shaping filter |
| rate_2m | input | 1 | 1 selects the 2 Mb/s coefficient, 0 selects the 1 Mb/s coefficient |
| trim_en | input | 1 | Enables the gain trim |
| coef_1m | input | 3 | Trim coefficient for 1 Mb/s; bit 2 is the direction, bits [1:0] the step count |
| coef_2m | input | 3 | Trim coefficient for 2 Mb/s, same encoding |
| direct_en | input | 1 | Outputs direct_value in place of the sample |
| direct_value | input | 8 | Constant output value used in direct mode |
| out_valid | output | 1 | Output qualifier, in_valid delayed by one cycle |
| out_sample | output | 8 | Registered, signed output sample |

## Verification
Every 8-bit sample value is combined with all eight coefficient codes at both rates. This separates the two directions, shows the flooring of negative products, and reaches both saturation corners. In each case the unselected coefficient field carries the bitwise complement of the selected one, so a swapped rate select gives a wrong value. A full sweep with the trim off and nonzero coefficients checks the unity path. Direct-mode cases with extreme samples and active trim show that the constant is not scaled. Idle cycles with changing inputs show that the output holds.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
   // direction encoding of the top coefficient bit
   typedef enum logic {
      TRIM_DOWN = 1'b0,
      TRIM_UP   = 1'b1
   } trim_dir_e;
endpackage

// File: rtl/tfs_coef_select.sv
module tfs_coef_select #(
   parameter int COEF_W = 3
) (
   input  logic              rate_2m,
   input  logic [COEF_W-1:0] coef_1m,
   input  logic [COEF_W-1:0] coef_2m,
   output logic [COEF_W-1:0] coef_act
);
   generate
      if (COEF_W < 2) begin : g_bad_width
         $error("tfs_coef_select: COEF_W must be at least 2");
      end
   endgenerate

   assign coef_act = rate_2m ? coef_2m : coef_1m;
endmodule

// File: rtl/tfs_gain_core.sv
module tfs_gain_core
   import tfs_pkg::*;
#(
   parameter int SAMPLE_W   = 8,
   parameter int COEF_W     = 3,
   parameter int FRAC_SHIFT = 4,
   parameter bit SATURATE   = 1'b1
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic        [COEF_W-1:0]   coef,
   output logic signed [SAMPLE_W-1:0] trimmed
);
   localparam int MAG_W  = COEF_W - 1;
   localparam int PROD_W = SAMPLE_W + MAG_W + 1;
   localparam int SUM_W  = PROD_W + 1;
   localparam logic signed [SUM_W-1:0] HI_LIM =
      {{(SUM_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] LO_LIM =
      {{(SUM_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("tfs_gain_core: SAMPLE_W must be at least 2");
      end
      if (COEF_W < 2) begin : g_bad_coef
         $error("tfs_gain_core: COEF_W must be at least 2");
      end
      if (FRAC_SHIFT < 1) begin : g_bad_shift
         $error("tfs_gain_core: FRAC_SHIFT must be at least 1");
      end
   endgenerate

   trim_dir_e                 dir;
   logic signed [MAG_W:0]     mag_s;
   logic signed [PROD_W-1:0]  prod;
   logic signed [PROD_W-1:0]  delta;
   logic signed [SUM_W-1:0]   sum;

   assign dir   = trim_dir_e'(coef[COEF_W-1]);
   assign mag_s = {1'b0, coef[MAG_W-1:0]};
   assign prod  = PROD_W'(sample) * PROD_W'(mag_s);
   assign delta = prod >>> FRAC_SHIFT;
   assign sum   = (dir == TRIM_UP) ? (SUM_W'(sample) + SUM_W'(delta))
                                   : (SUM_W'(sample) - SUM_W'(delta));

   generate
      if (SATURATE) begin : g_clamp
         always_comb begin
            if (sum > HI_LIM)      trimmed = HI_LIM[SAMPLE_W-1:0];
            else if (sum < LO_LIM) trimmed = LO_LIM[SAMPLE_W-1:0];
            else                   trimmed = sum[SAMPLE_W-1:0];
         end
      end else begin : g_wrap
         assign trimmed = sum[SAMPLE_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/tx_fine_scaler.sv
module tx_fine_scaler #(
   parameter int SAMPLE_W   = 8,
   parameter int COEF_W     = 3,
   parameter int FRAC_SHIFT = 4,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                rate_2m,
   input  logic                trim_en,
   input  logic [COEF_W-1:0]   coef_1m,
   input  logic [COEF_W-1:0]   coef_2m,
   input  logic                direct_en,
   input  logic [SAMPLE_W-1:0] direct_value,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample
);
   logic [COEF_W-1:0]          coef_act;
   logic signed [SAMPLE_W-1:0] trimmed;
   logic [SAMPLE_W-1:0]        next_sample;

   tfs_coef_select #(.COEF_W(COEF_W)) u_sel (
      .rate_2m  (rate_2m),
      .coef_1m  (coef_1m),
      .coef_2m  (coef_2m),
      .coef_act (coef_act)
   );

   tfs_gain_core #(
      .SAMPLE_W   (SAMPLE_W),
      .COEF_W     (COEF_W),
      .FRAC_SHIFT (FRAC_SHIFT),
      .SATURATE   (SATURATE)
   ) u_core (
      .sample  ($signed(in_sample)),
      .coef    (coef_act),
      .trimmed (trimmed)
   );

   always_comb begin
      if (direct_en)    next_sample = direct_value;
      else if (trim_en) next_sample = trimmed;
      else              next_sample = in_sample;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= next_sample;
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sample)); // R9

   AST_DIRECT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && direct_en) |=> (out_sample == $past(direct_value))); // R8

   AST_BYPASS_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !direct_en && !trim_en) |=> (out_sample == $past(in_sample))); // R7

   AST_SHRINK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !direct_en && trim_en && !coef_act[COEF_W-1] && !in_sample[SAMPLE_W-1])
      |=> !out_sample[SAMPLE_W-1]); // R4
endmodule

// File: tb/sim_tx_fine_scaler.sv
module sim_tx_fine_scaler;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [7:0] in_sample;
   logic       rate_2m;
   logic       trim_en;
   logic [2:0] coef_1m;
   logic [2:0] coef_2m;
   logic       direct_en;
   logic [7:0] direct_value;
   logic       out_valid;
   logic [7:0] out_sample;

   int compared = 0;
   int mismatched = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tx_fine_scaler u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .rate_2m(rate_2m), .trim_en(trim_en), .coef_1m(coef_1m), .coef_2m(coef_2m),
      .direct_en(direct_en), .direct_value(direct_value),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic int floor16(input int p);
      int r;
      r = ((p % 16) + 16) % 16;
      return (p - r) / 16;
   endfunction

   function automatic logic [7:0] model(input int s, input logic [2:0] c);
      int m, v;
      m = int'(c[1:0]);
      v = c[2] ? s + floor16(s * m) : s - floor16(s * m);
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      return 8'(v);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at negedge, capture at posedge, observe 1 time unit later
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog R2: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] held;
      rst_n = 1'b0; in_valid = 1'b0; in_sample = 8'h55; rate_2m = 1'b0;
      trim_en = 1'b0; coef_1m = 3'd0; coef_2m = 3'd0; direct_en = 1'b0;
      direct_value = 8'h00;
      repeat (3) step();
      // R1: reset state
      check("R1 valid", {7'd0, out_valid}, 8'd0);
      check("R1 sample", out_sample, 8'd0);
      @(negedge clk) rst_n = 1'b1;

      // R3 R4 R5 R6: exhaustive trim sweep at both rates
      for (int rt = 0; rt < 2; rt++) begin
         for (int c = 0; c < 8; c++) begin
            for (int s = -128; s < 128; s++) begin
               @(negedge clk);
               in_valid = 1'b1; trim_en = 1'b1; direct_en = 1'b0;
               rate_2m = rt[0];
               in_sample = 8'(s);
               if (rt == 0) begin coef_1m = 3'(c); coef_2m = ~3'(c); end
               else         begin coef_2m = 3'(c); coef_1m = ~3'(c); end
               step();
               check(c[2] ? "R3 R5 R6 up" : "R4 R6 down", out_sample, model(s, 3'(c)));
               check("R2 valid", {7'd0, out_valid}, 8'd1);
            end
         end
      end

      // R7: trim disabled, coefficients nonzero
      for (int s = -128; s < 128; s++) begin
         @(negedge clk);
         trim_en = 1'b0; coef_1m = 3'b111; coef_2m = 3'b011; rate_2m = s[0];
         in_sample = 8'(s);
         step();
         check("R7 bypass", out_sample, 8'(s));
      end

      // R8: direct mode overrides trim and sample
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         direct_en = 1'b1; trim_en = k[0]; rate_2m = k[1];
         coef_1m = 3'b111; coef_2m = 3'b111;
         in_sample = k[2] ? 8'h7f : 8'h80;
         direct_value = 8'(k * 37 + 120);
         step();
         check("R8 direct", out_sample, 8'(k * 37 + 120));
      end

      // R9 R2: idle cycles hold output while inputs change
      held = out_sample;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         in_valid = 1'b0; direct_en = k[0]; trim_en = 1'b1;
         direct_value = 8'(k + 1); in_sample = 8'(k * 50);
         step();
         check("R9 hold", out_sample, held);
         check("R2 idle valid", {7'd0, out_valid}, 8'd0);
      end

      // R2: valid returns one cycle after in_valid
      @(negedge clk);
      in_valid = 1'b1; direct_en = 1'b0; trim_en = 1'b0; in_sample = 8'h33;
      step();
      check("R2 rise", {7'd0, out_valid}, 8'd1);
      check("R7 after idle", out_sample, 8'h33);

      finish_run();
   end
endmodule